// File: doc/BRIEF.md
# Scratchpad / FIFO Level Read Multiplexer

This block is one register slot that serves two purposes from a single address. While the swap control input is low, the slot is an ordinary 8-bit scratchpad. Software can write any byte to it and read the byte back. While the swap control is high, writes go instead to a write-only mode register, and reads return a FIFO occupancy count in place of the scratchpad contents.

The two low mode bits select what a read returns. It can be the receive FIFO level, the transmit FIFO level, or the two levels in turn on successive read strobes. Alternation always restarts with the receive level after a mode write. Mode bit 3 sets the polarity of an automatic half-duplex direction output, which follows the transmitter's activity. Mode bit 2 is reserved and is not stored.

The FIFOs are outside this block. Their level counts arrive as 7-bit inputs, which cover the counts 0 to 64, and each is zero-extended to 8 bits when read. The scratchpad keeps its value while the swap control is high.

Top module: `scr_lvl_mux`

## Requirements
- R1: After reset the scratchpad holds 0xFF, and a read with the swap control low returns 0xFF.
- R2: With the swap control low, a write stores wr_data in the scratchpad, and later reads return that value.
- R3: With the swap control high, a write updates the mode register and leaves the scratchpad unchanged. The old scratchpad value reads back once the swap control is low again.
- R4: With the swap control high and mode bit 0 = 0 (mode bits 00 or 10), a read returns the receive level zero-extended to 8 bits.
- R5: With the swap control high and mode bits = 01, a read returns the transmit level zero-extended to 8 bits.
- R6: With the swap control high and mode bits = 11, successive read strobes return the receive level first, then the transmit level, and keep alternating. Only a read strobe in this mode advances the alternation.
- R7: Reset and every write with the swap control high restart the alternation at the receive level. A write wins over a read strobe given in the same cycle.
- R8: dir_out equals the inverse of tx_active while mode bit 3 = 0, and equals tx_active while mode bit 3 = 1.
- R9: With the swap control low, the mode bits have no effect: reads return the scratchpad, and read strobes do not advance the alternation.
- R10: After reset the mode bits are 00, so receive level is selected, and mode bit 3 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_en | input | 1 | Swap control: high routes writes to the mode register and reads to the FIFO levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; advances the alternation |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid in the cycle of the read strobe |
| rx_lvl | input | 7 | Receive FIFO occupancy |
| tx_lvl | input | 7 | Transmit FIFO occupancy |
| tx_active | input | 1 | High while the transmitter is sending |
| dir_out | output | 1 | Half-duplex direction output |

## Verification
The bench builds the block with its default widths: an 8-bit data path, 7-bit level inputs and a scratchpad reset value of 0xFF. With these values, level counts up to 64 reach the top bit of the level input, and the zero-extension into bit 7 is checked directly. The random phase mixes swap toggles, mode writes with every mode code, and read strobes. This reaches the alternation restart after a mode write, write-and-read collisions, and scratchpad retention across swaps.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic [1:0] {
        LV_RX  = 2'd0,
        LV_TX  = 2'd1,
        LV_ALT = 2'd2
    } lvl_src_e;

    typedef struct packed {
        logic       inv_dir;
        logic [1:0] sel_bits;
    } mode_t;

    localparam mode_t MODE_RST = '{inv_dir: 1'b0, sel_bits: 2'b00};

    // bit 0 clear selects RX regardless of bit 1
    function automatic lvl_src_e decode_src(input logic [1:0] bits);
        if (!bits[0])      return LV_RX;
        else if (!bits[1]) return LV_TX;
        else               return LV_ALT;
    endfunction

endpackage

// File: rtl/scr_store.sv
module scr_store #(
    parameter int                 DATA_W  = 8,
    parameter logic [DATA_W-1:0]  RST_VAL = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= RST_VAL;
        else if (we) q <= d;
    end
endmodule

// File: rtl/scr_mode_reg.sv
module scr_mode_reg
    import scr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [1:0] sel_in,
    input  logic       inv_in,
    input  logic       tx_active,
    output mode_t      mode,
    output logic       dir_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_RST;
        end else if (we) begin
            mode.sel_bits <= sel_in;
            mode.inv_dir  <= inv_in;
        end
    end

    assign dir_out = mode.inv_dir ? tx_active : ~tx_active;

    // R8
    dir_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_active != $past(tx_active) && mode.inv_dir == $past(mode.inv_dir))
        |-> (dir_out != $past(dir_out)));
endmodule

// File: rtl/scr_rd_seq.sv
module scr_rd_seq
    import scr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  logic     rd_en,
    input  logic     swap_en,
    input  lvl_src_e src,
    output logic     pick_tx
);
    logic advance;
    assign advance = rd_en && swap_en && (src == LV_ALT);

    always_ff @(posedge clk) begin
        if (rst || restart) pick_tx <= 1'b0;
        else if (advance)   pick_tx <= ~pick_tx;
    end

    // R6
    alt_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !restart) |=> (pick_tx != $past(pick_tx)));

    // R7
    alt_restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !pick_tx);

    // R9
    alt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!swap_en && !restart) |=> $stable(pick_tx));
endmodule

// File: rtl/scr_lvl_mux.sv
module scr_lvl_mux
    import scr_pkg::*;
#(
    parameter int                DATA_W  = 8,
    parameter int                LVL_W   = 7,
    parameter logic [DATA_W-1:0] SCR_RST = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              swap_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [LVL_W-1:0]  rx_lvl,
    input  logic [LVL_W-1:0]  tx_lvl,
    input  logic              tx_active,
    output logic              dir_out
);
    localparam int PAD_W = DATA_W - LVL_W;

    logic [DATA_W-1:0] scr_q;
    mode_t             mode;
    lvl_src_e          src;
    logic              pick_tx;
    logic              mode_we;
    logic [DATA_W-1:0] rx_ext, tx_ext;

    assign mode_we = wr_en && swap_en;
    assign rx_ext  = {{PAD_W{1'b0}}, rx_lvl};
    assign tx_ext  = {{PAD_W{1'b0}}, tx_lvl};

    scr_store #(.DATA_W(DATA_W), .RST_VAL(SCR_RST)) u_store (
        .clk (clk),
        .rst (rst),
        .we  (wr_en && !swap_en),
        .d   (wr_data),
        .q   (scr_q)
    );

    scr_mode_reg u_mode (
        .clk       (clk),
        .rst       (rst),
        .we        (mode_we),
        .sel_in    (wr_data[1:0]),
        .inv_in    (wr_data[3]),
        .tx_active (tx_active),
        .mode      (mode),
        .dir_out   (dir_out)
    );

    assign src = decode_src(mode.sel_bits);

    scr_rd_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .restart (mode_we),
        .rd_en   (rd_en),
        .swap_en (swap_en),
        .src     (src),
        .pick_tx (pick_tx)
    );

    always_comb begin
        if (!swap_en) begin
            rd_data = scr_q;
        end else begin
            unique case (src)
                LV_TX:   rd_data = tx_ext;
                LV_ALT:  rd_data = pick_tx ? tx_ext : rx_ext;
                default: rd_data = rx_ext;
            endcase
        end
    end

    // R1
    scr_reset_chk: assert property (@(posedge clk)
        rst |=> (scr_q == SCR_RST));

    // R3
    scr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        mode_we |=> $stable(scr_q));

    // R4
    lvl_msb_chk: assert property (@(posedge clk) disable iff (rst)
        swap_en |-> (rd_data[DATA_W-1] == 1'b0));
endmodule

// File: tb/test_scr_lvl_mux.sv
module test_scr_lvl_mux;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       swap_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, tx_active = 1'b0;
    logic [7:0] wr_data = '0;
    logic [6:0] rx_lvl = '0, tx_lvl = '0;
    logic [7:0] rd_data;
    logic       dir_out;

    int errs = 0, checks = 0;

    // independent model
    logic [7:0] m_scr;
    logic [1:0] m_sel;
    logic       m_inv, m_alt;

    always #2 clk = ~clk;

    scr_lvl_mux i_scr_lvl_mux (
        .clk(clk), .rst(rst), .swap_en(swap_en), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .rx_lvl(rx_lvl), .tx_lvl(tx_lvl),
        .tx_active(tx_active), .dir_out(dir_out)
    );

    function automatic logic [7:0] exp_read();
        if (!swap_en)        return m_scr;
        if (!m_sel[0])       return {1'b0, rx_lvl};
        if (m_sel == 2'b01)  return {1'b0, tx_lvl};
        return m_alt ? {1'b0, tx_lvl} : {1'b0, rx_lvl};
    endfunction

    function automatic logic exp_dir();
        return m_inv ? tx_active : ~tx_active;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic model_step();
        if (rst) begin
            m_scr = 8'hFF; m_sel = 2'b00; m_inv = 1'b0; m_alt = 1'b0;
        end else if (wr_en && swap_en) begin
            m_sel = wr_data[1:0]; m_inv = wr_data[3]; m_alt = 1'b0;
        end else if (wr_en) begin
            m_scr = wr_data;
        end else if (rd_en && swap_en && m_sel == 2'b11) begin
            m_alt = ~m_alt;
        end
        if (wr_en && !swap_en && rd_en && m_sel == 2'b11) begin
            // plain write with read strobe and swap low: no advance
        end
    endtask

    // one cycle: drive at negedge, sample 1 ns later, update model at posedge
    task automatic cycle(input logic sw, input logic we, input logic re,
                         input logic [7:0] d, input string req);
        @(negedge clk);
        swap_en = sw; wr_en = we; rd_en = re; wr_data = d;
        #1;
        if (re) check8(req, rd_data, exp_read());
        check8("R8", {7'd0, dir_out}, {7'd0, exp_dir()});
        @(posedge clk);
        model_step();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        #150000;
        errs++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rx_lvl = 7'd17; tx_lvl = 7'd42;
        repeat (3) @(posedge clk);
        model_step();
        @(negedge clk); rst = 1'b0;

        // R1 reset value
        cycle(1'b0, 1'b0, 1'b1, 8'h00, "R1");
        // R10 reset mode: RX, polarity 0
        cycle(1'b1, 1'b0, 1'b1, 8'h00, "R10");
        tx_active = 1'b1;
        cycle(1'b1, 1'b0, 1'b0, 8'h00, "R10");
        // R2 scratch write/read
        cycle(1'b0, 1'b1, 1'b0, 8'h5A, "R2");
        cycle(1'b0, 1'b0, 1'b1, 8'h00, "R2");
        // R3 mode write leaves scratch
        cycle(1'b1, 1'b1, 1'b0, 8'h0B, "R3");
        cycle(1'b0, 1'b0, 1'b1, 8'h00, "R3");
        // R9 read strobes with swap low do not advance; R6 starts at RX
        cycle(1'b0, 1'b0, 1'b1, 8'h00, "R9");
        rx_lvl = 7'd64; tx_lvl = 7'd0;
        cycle(1'b1, 1'b0, 1'b1, 8'h00, "R6");
        cycle(1'b1, 1'b0, 1'b1, 8'h00, "R6");
        cycle(1'b1, 1'b0, 1'b1, 8'h00, "R6");
        // R7 mode write restarts, write beats read
        cycle(1'b1, 1'b1, 1'b1, 8'h03, "R7");
        cycle(1'b1, 1'b0, 1'b1, 8'h00, "R7");
        // R5 TX mode, R4 mode 10 gives RX
        cycle(1'b1, 1'b1, 1'b0, 8'h01, "R5");
        cycle(1'b1, 1'b0, 1'b1, 8'h00, "R5");
        cycle(1'b1, 1'b1, 1'b0, 8'h02, "R4");
        cycle(1'b1, 1'b0, 1'b1, 8'h00, "R4");
        // R8 polarity flip both ways
        tx_active = 1'b0;
        cycle(1'b1, 1'b1, 1'b0, 8'h08, "R8");
        tx_active = 1'b1;
        cycle(1'b1, 1'b0, 1'b0, 8'h00, "R8");

        for (int i = 0; i < 400; i++) begin
            logic [7:0] d;
            int op;
            rx_lvl = 7'($urandom_range(0, 64));
            tx_lvl = 7'($urandom_range(0, 64));
            tx_active = 1'($urandom);
            d = 8'($urandom);
            op = $urandom_range(0, 9);
            case (op)
                0, 1:    cycle(1'b1, 1'b1, 1'b0, d, "R7");
                2:       cycle(1'b0, 1'b1, 1'b0, d, "R2");
                3:       cycle(1'b0, 1'b0, 1'b1, d, "R9");
                4:       cycle(1'b1, 1'b1, 1'b1, d, "R7");
                default: cycle(1'b1, 1'b0, 1'b1, d, "R6");
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule